// File: doc/BRIEF.md
# ALU with Status Flag Register

This block is an integer arithmetic and logic unit for a 16-bit datapath that also executes byte-wide operations. Each accepted operation supplies two operands, an operation code, a width select and a class tag. One cycle later it presents the masked result and an updated flag word. The flag word holds six status flags and three control bits.

The six status flags are carry, parity, auxiliary carry, zero, sign and overflow. Only arithmetic and logic operations of the arithmetic class change them. A move operation, and any operation tagged as data-transfer or control class, still produces a result but leaves every status flag as it was. The three control bits are trap, interrupt enable and direction. They are written only by dedicated set and clear strobes, and no operation changes them. Add-with-carry and subtract-with-borrow take their carry-in from the stored carry flag, so multi-word arithmetic can be chained one operation per cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: An active-low asynchronous reset immediately clears `result_o`, `valid_o` and all nine bits of `flags_o`.
- R2: For each cycle with `valid_i` high, `valid_o` is high in the next cycle and `result_o` holds the result: op 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 move (result is operand b). With `wide_i` low the operands are truncated to 8 bits and result bits 15..8 are zero. With `valid_i` low, `valid_o` is low in the next cycle.
- R3: Carry (flags bit 0) is the carry out of the result MSB (bit 7 for byte, bit 15 for word) on add, and the borrow into it on subtract. Ops 1 and 3 add or subtract the stored carry flag as well.
- R4: Auxiliary carry (bit 2) is the carry or borrow out of result bit 3 into bit 4, and it includes the stored carry for ops 1 and 3.
- R5: Overflow (bit 5) is 1 when the two's complement result of an add or subtract is outside the range of the selected width.
- R6: Zero (bit 3) is 1 when the masked result is 0. Sign (bit 4) equals the result MSB of the selected width.
- R7: Parity (bit 1) is 1 when the low 8 result bits contain an even number of ones, for both widths.
- R8: Ops 4, 5 and 6 clear carry, auxiliary carry and overflow.
- R9: The status flags (bits 5..0) change only on an accepted operation with class `cls_i` = 0 and op not 7. Class 1 (transfer), class 2 (control), class 3, op 7, and cycles with `valid_i` low leave them unchanged.
- R10: `ctl_set_i[k]` and `ctl_clr_i[k]` (k=0 trap, 1 interrupt enable, 2 direction) write flags bit 6+k at the next edge. Clear wins when both are high. A bit with neither strobe high holds. Strobes never alter bits 5..0, and operations never alter bits 8..6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| op_i | input | 3 | Operation code |
| cls_i | input | 2 | Operation class: 0 arithmetic/logic, 1 transfer, 2 control |
| wide_i | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| ctl_set_i | input | 3 | Set strobes for trap, interrupt enable, direction |
| ctl_clr_i | input | 3 | Clear strobes for the same bits |
| valid_o | output | 1 | Result registered this cycle |
| result_o | output | 16 | Registered result |
| flags_o | output | 9 | Flag word: 0 C, 1 P, 2 A, 3 Z, 4 S, 5 O, 6 trap, 7 intr, 8 dir |

## Verification
The result, `valid_o` and the status flags of an operation appear together in the cycle after the edge that samples it. A driven operation therefore matches the first `valid_o` seen at the following falling edge. The scoreboard pushes the expected result and flag word when it drives, and pops it when `valid_o` is seen. A control strobe is judged at the falling edge after the one it was driven on. A reset is judged before any clock edge occurs, which shows that it acts asynchronously.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned STAT_W = 6;
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned FLAG_W = STAT_W + CTL_W;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_MOV = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0, CLS_XFER = 2'd1, CLS_CTRL = 2'd2, CLS_RSVD = 2'd3
  } op_cls_e;

  // bit 0 is carry
  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cy;
  } stat_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned NIB_W    = 4
) (
  input  alu_op_e             op_i,
  input  logic                wide_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                cin_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                cy_o,
  output logic                aux_o,
  output logic                ovf_o
);
  localparam int unsigned HI_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] mask, a_m, b_m;
  logic [DATA_W:0]   ext, ci_w;
  logic [NIB_W:0]    nib, ci_n;
  logic              sub_op, arith_op, ci;
  logic              sa, sb, sr, ovf_add, ovf_sub;
  logic [DATA_W-1:0] arith_res;

  assign mask     = wide_i ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
  assign a_m      = a_i & mask;
  assign b_m      = b_i & mask;
  assign sub_op   = (op_i == OP_SUB) || (op_i == OP_SBB);
  assign arith_op = (op_i == OP_ADD) || (op_i == OP_ADC) || sub_op;
  assign ci       = ((op_i == OP_ADC) || (op_i == OP_SBB)) & cin_i;
  assign ci_w     = {{DATA_W{1'b0}}, ci};
  assign ci_n     = {{NIB_W{1'b0}}, ci};

  always_comb begin
    if (sub_op) begin
      ext = {1'b0, a_m} - {1'b0, b_m} - ci_w;
      nib = {1'b0, a_m[NIB_W-1:0]} - {1'b0, b_m[NIB_W-1:0]} - ci_n;
    end else begin
      ext = {1'b0, a_m} + {1'b0, b_m} + ci_w;
      nib = {1'b0, a_m[NIB_W-1:0]} + {1'b0, b_m[NIB_W-1:0]} + ci_n;
    end
  end

  assign arith_res = ext[DATA_W-1:0] & mask;
  assign sa      = wide_i ? a_m[DATA_W-1] : a_m[NARROW_W-1];
  assign sb      = wide_i ? b_m[DATA_W-1] : b_m[NARROW_W-1];
  assign sr      = wide_i ? arith_res[DATA_W-1] : arith_res[NARROW_W-1];
  assign ovf_add = (sa == sb) && (sr != sa);
  assign ovf_sub = (sa != sb) && (sr != sa);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_m & b_m;
      OP_OR:   res_o = a_m | b_m;
      OP_XOR:  res_o = a_m ^ b_m;
      OP_MOV:  res_o = b_m;
      default: res_o = arith_res;
    endcase
  end

  // logic and move clear carry, aux and overflow
  assign cy_o  = arith_op & (wide_i ? ext[DATA_W] : ext[NARROW_W]);
  assign aux_o = arith_op & nib[NIB_W];
  assign ovf_o = arith_op & (sub_op ? ovf_sub : ovf_add);
endmodule

// File: rtl/flag_eval.sv
module flag_eval #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned PAR_W    = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              wide_i,
  output logic              par_o,
  output logic              zero_o,
  output logic              sign_o
);
  assign par_o  = ~(^res_i[PAR_W-1:0]);
  assign zero_o = (res_i == '0);
  assign sign_o = wide_i ? res_i[DATA_W-1] : res_i[NARROW_W-1];
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_flag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  stat_t            stat_i,
  input  logic [CTL_W-1:0] set_i,
  input  logic [CTL_W-1:0] clr_i,
  output stat_t            stat_o,
  output logic [CTL_W-1:0] ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_o <= '0;
    else if (upd_i) stat_o <= stat_i;
  end

  for (genvar k = 0; k < CTL_W; k++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ctl_o[k] <= 1'b0;
      else if (clr_i[k]) ctl_o[k] <= 1'b0;
      else if (set_i[k]) ctl_o[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [2:0]                op_i,
  input  logic [1:0]                cls_i,
  input  logic                      wide_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  input  logic [CTL_W-1:0]          ctl_set_i,
  input  logic [CTL_W-1:0]          ctl_clr_i,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         result_o,
  output logic [FLAG_W-1:0]         flags_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] res;
  logic              cy, aux, ovf, par, zero, sign, upd;
  stat_t             stat_d, stat_q;
  logic [CTL_W-1:0]  ctl_q;

  assign op = alu_op_e'(op_i);

  alu_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .op_i   (op),
    .wide_i (wide_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (stat_q.cy),
    .res_o  (res),
    .cy_o   (cy),
    .aux_o  (aux),
    .ovf_o  (ovf)
  );

  flag_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .PAR_W(NARROW_W)) u_eval (
    .res_i  (res),
    .wide_i (wide_i),
    .par_o  (par),
    .zero_o (zero),
    .sign_o (sign)
  );

  assign upd    = valid_i && (op_cls_e'(cls_i) == CLS_ALU) && (op != OP_MOV);
  assign stat_d = '{ovf: ovf, sign: sign, zero: zero, aux: aux, par: par, cy: cy};

  flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .stat_i (stat_d),
    .set_i  (ctl_set_i),
    .clr_i  (ctl_clr_i),
    .stat_o (stat_q),
    .ctl_o  (ctl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res;
    end
  end

  assign flags_o = {ctl_q, stat_q};
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [1:0]        cls_i,
  input logic              wide_i,
  input logic [2:0]        ctl_set_i,
  input logic [2:0]        ctl_clr_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [8:0]        flags_o
);
  logic upd_q, wide_q;
  logic acc;
  assign acc = valid_i && (cls_i == 2'd0) && (op_i != 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      upd_q <= acc;
      if (valid_i) wide_q <= wide_i;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wide_q) |-> (result_o[DATA_W-1:NARROW_W] == '0)); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (flags_o[3] == (result_o == '0))); // R6
  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (flags_o[4] == (wide_q ? result_o[DATA_W-1] : result_o[NARROW_W-1]))); // R6
  AST_PARITY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (flags_o[1] == ~(^result_o[7:0]))); // R7
  AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i >= 3'd4) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0 && flags_o[5] == 1'b0)); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(flags_o[5:0])); // R9
  AST_CTL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ctl_set_i & ~ctl_clr_i)) |=>
      ((flags_o[8:6] & $past(ctl_set_i & ~ctl_clr_i)) == $past(ctl_set_i & ~ctl_clr_i))); // R10
  AST_CTL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ctl_clr_i) |=> ((flags_o[8:6] & $past(ctl_clr_i)) == 3'b000)); // R10
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_set_i | ctl_clr_i) == 3'b000) |=> $stable(flags_o[8:6])); // R10
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  cls_i = '0;
  logic        wide_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [2:0]  set_i = '0, clr_i = '0;
  logic        valid_o;
  logic [15:0] result_o;
  logic [8:0]  flags_o;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [8:0] m_fl = '0;

  typedef struct { logic [15:0] res; logic [8:0] fl; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  alu_flag_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .cls_i(cls_i),
    .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .ctl_set_i(set_i), .ctl_clr_i(clr_i),
    .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic send(int op, int cls, bit wide, int a, int b, string tag);
    int mx, hb, av, bv, ci, full, sa, sb, sfull, res, ones;
    bit cy, ax, ov;
    exp_t e;
    mx = wide ? 65535 : 255;
    hb = wide ? 32768 : 128;
    av = a & mx; bv = b & mx;
    ci = (op == 1 || op == 3) ? int'(m_fl[0]) : 0;
    sa = (av >= hb) ? av - 2*hb : av;
    sb = (bv >= hb) ? bv - 2*hb : bv;
    cy = 0; ax = 0; ov = 0;
    case (op)
      0, 1: begin
        full = av + bv + ci; res = full & mx; cy = full > mx;
        ax = ((av % 16) + (bv % 16) + ci) > 15;
        sfull = sa + sb + ci; ov = (sfull > hb - 1) || (sfull < -hb);
      end
      2, 3: begin
        full = av - bv - ci; res = full & mx; cy = full < 0;
        ax = ((av % 16) - (bv % 16) - ci) < 0;
        sfull = sa - sb - ci; ov = (sfull > hb - 1) || (sfull < -hb);
      end
      4: res = av & bv;
      5: res = av | bv;
      6: res = av ^ bv;
      default: res = bv;
    endcase
    if (cls == 0 && op != 7) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
      m_fl[0] = cy;
      m_fl[1] = (ones % 2) == 0;
      m_fl[2] = ax;
      m_fl[3] = (res == 0);
      m_fl[4] = (res >= hb);
      m_fl[5] = ov;
    end
    @(negedge clk);
    valid_i = 1'b1; op_i = op[2:0]; cls_i = cls[1:0]; wide_i = wide;
    a_i = a[15:0]; b_i = b[15:0];
    e.res = res[15:0]; e.fl = m_fl; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(logic [2:0] s, logic [2:0] c, string tag);
    @(negedge clk);
    set_i = s; clr_i = c;
    m_fl[8:6] = (m_fl[8:6] | s) & ~c;
    @(negedge clk);
    set_i = '0; clr_i = '0;
    #1 check(flags_o == m_fl, tag, 32'(flags_o), 32'(m_fl));
  endtask

  // monitor: results are due at the falling edge after the capturing edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && valid_o) begin
        if (sb_q.size() == 0) begin
          check(0, "R2 unexpected valid_o", 32'(valid_o), 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(result_o == e.res, {e.tag, " result"}, 32'(result_o), 32'(e.res));
          check(flags_o == e.fl, {e.tag, " flags"}, 32'(flags_o), 32'(e.fl));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] held;
    #1 check(flags_o == 9'd0 && result_o == 16'd0 && valid_o == 1'b0, "R1 reset state",
             32'(flags_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    send(0, 0, 0, 'h0F, 'h01, "R4 byte add nibble carry");
    send(0, 0, 0, 'hFF, 'h01, "R3 R6 byte add wrap to zero");
    send(1, 0, 0, 'h10, 'h20, "R3 adc uses stored carry");
    send(0, 0, 1, 'h7FFF, 'h0001, "R5 word add overflow");
    send(2, 0, 0, 'h00, 'h01, "R3 R4 byte sub borrow");
    send(3, 0, 1, 'h1000, 'h0FFF, "R3 sbb uses stored borrow");
    send(2, 0, 0, 'h80, 'h01, "R5 byte sub overflow");
    send(0, 0, 1, 'h00FF, 'h0001, "R7 word parity low byte");
    send(0, 0, 0, 'hFF, 'hFF, "R3 set carry before logic");
    send(4, 0, 0, 'hF0, 'h3C, "R8 and clears carry");
    send(0, 0, 0, 'h7F, 'h7F, "R5 set overflow before logic");
    send(5, 0, 1, 'h8001, 'h0100, "R8 R6 or word sign");
    send(6, 0, 0, 'h5A, 'h5A, "R8 R6 xor to zero");
    send(0, 0, 0, 'h0F, 'h0F, "R4 set aux before move");
    send(7, 0, 1, 'h1234, 'h0000, "R9 move keeps flags");
    send(0, 1, 1, 'hFFFF, 'h0001, "R9 transfer class keeps flags");
    send(2, 2, 0, 'h00, 'h01, "R9 control class keeps flags");
    send(0, 0, 0, 'h1234, 'h0001, "R2 byte op masks operands");
    idle(2);
    check(sb_q.size() == 0, "R2 all results delivered", sb_q.size(), 0);

    // inputs toggled with valid_i low
    held = flags_o;
    @(negedge clk);
    op_i = 3'd2; cls_i = 2'd0; a_i = 16'h0000; b_i = 16'h0001; wide_i = 1'b1;
    repeat (2) @(negedge clk);
    #1 check(flags_o == held && valid_o == 1'b0, "R9 no valid no change", 32'(flags_o), 32'(held));

    ctl(3'b111, 3'b000, "R10 set all control bits");
    ctl(3'b010, 3'b010, "R10 clear wins over set");
    ctl(3'b000, 3'b101, "R10 clear trap and direction");
    ctl(3'b100, 3'b000, "R10 set direction only");
    send(2, 0, 1, 'h0000, 'h0001, "R10 op keeps control bits");
    idle(2);

    for (int n = 0; n < 400; n++) begin
      int rop, rcls;
      rop = int'($urandom_range(0, 7));
      rcls = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0;
      send(rop, rcls, 1'($urandom_range(0, 1)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), "R3 R4 R5 R6 R7 random op");
    end
    idle(2);
    check(sb_q.size() == 0, "R2 random results delivered", sb_q.size(), 0);

    // asynchronous reset, judged before any clock edge
    #1.2 rst_n = 1'b0;
    m_fl = '0;
    #0.3 check(flags_o == 9'd0 && result_o == 16'd0 && valid_o == 1'b0, "R1 async reset",
               32'(flags_o), 32'd0);
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule